// File: doc/BRIEF.md
# Word Address Counter with Page and Array Wrap

This block holds the internal word address of a byte-addressed serial memory slave. A protocol front end, outside this block, hands it the two address bytes it receives after the device select phase. After each data byte it moves the address forward with one of two strobes, depending on whether that byte was written into the array or read out of it.

The two strobes wrap the address differently. A write step moves only the offset inside the current 64-byte page, so a long write burst loops within one page. A read step moves the whole 14-bit address, so a long read burst runs across pages and wraps from the top of the 16,384-byte array back to zero. Between transactions the counter keeps its value. A read that has no address phase therefore starts at the byte after the one accessed last.

The first address byte is held in a staging register. The address register changes only when the second byte arrives, so a transaction cut short after its first address byte leaves the current address untouched. Every output is registered and shows the result of a strobe one clock after the edge that samples it.

Top module: `word_addr_ctr`

## Requirements
- R1: While `rst_n` is low, the address and the staged high bits clear to 0. After reset is released, `addr_o` reads 0 until a strobe changes it.
- R2: A `ld_hi_i` pulse stores bits 5:0 of `addr_byte_i` as the staged high part of the address. Bits 7:6 of that byte are ignored. `addr_o` does not change because of `ld_hi_i` alone.
- R3: A `ld_lo_i` pulse loads `addr_o` with {staged bits, `addr_byte_i`}. The staged bits go to bits 13:8 and the byte goes to bits 7:0. The new value appears one clock later.
- R4: A `inc_wr_i` pulse adds one to bits 5:0 only, so offset 63 goes to offset 0. Bits 13:6 stay unchanged.
- R5: A `inc_rd_i` pulse adds one to the full 14-bit address, so 16383 (0x3FFF) goes to 0.
- R6: With no strobe asserted, `addr_o` holds its value for any number of cycles. A read with no address phase after a burst therefore starts at the last accessed address plus one.
- R7: When `ld_lo_i` is asserted, the load wins over either increment strobe raised in the same cycle.
- R8: When `inc_wr_i` and `inc_rd_i` are both asserted without a load, the page-wrapping write step is applied.
- R9: `row_o` always equals bits 13:6 of `addr_o`, and `col_o` always equals bits 5:0.
- R10: A `ld_hi_i` in the same cycle as `ld_lo_i` updates the staging register only for later loads. The load in that cycle uses the previously staged bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_hi_i | input | 1 | Stage the high address byte |
| ld_lo_i | input | 1 | Commit the low address byte together with the staged high bits |
| inc_wr_i | input | 1 | Step after a written byte (wraps within the page) |
| inc_rd_i | input | 1 | Step after a read byte (wraps across the whole array) |
| addr_byte_i | input | 8 | Received address byte |
| addr_o | output | 14 | Current word address |
| row_o | output | 8 | Page number, bits 13:6 |
| col_o | output | 6 | Offset within the page, bits 5:0 |

## Verification
A write burst longer than one page is started near the top of a page. It shows that page-mode stepping loops back to offset 0 of the same row and never carries into the row bits. Read steps are issued from 0x3FFE, which separates the full-width wrap to zero from the in-page wrap. Loads are sent with nonzero don't-care bits in the first byte, with increments raised in the same cycle, and with a new first byte raised together with the second, which exposes priority and staging mistakes. A long pseudo-random strobe stream, with idle gaps between bursts, checks persistence and every mixed ordering against the cycle model.

// File: rtl/wac_pkg.sv
package wac_pkg;

    localparam int WAC_ADDR_W = 14;
    localparam int WAC_PAGE_W = 6;
    localparam int WAC_BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_HOLD      = 2'd0,
        OP_LOAD      = 2'd1,
        OP_STEP_PAGE = 2'd2,
        OP_STEP_FLAT = 2'd3
    } wac_op_e;

endpackage

// File: rtl/wac_hi_stage.sv
module wac_hi_stage #(
    parameter int HI_W   = 6,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [HI_W-1:0]   hi_o
);

    typedef struct packed {
        logic [HI_W-1:0] hi;
    } stage_t;

    stage_t stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;
        if (ld_i) begin
            // only the bits that reach the address are kept
            stage_d.hi = byte_i[HI_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign hi_o = stage_q.hi;

endmodule

// File: rtl/wac_op_sel.sv
module wac_op_sel
    import wac_pkg::*;
(
    input  logic    ld_lo_i,
    input  logic    inc_wr_i,
    input  logic    inc_rd_i,
    output wac_op_e op_o
);

    // fixed priority: load, then write step, then read step
    always_comb begin
        if (ld_lo_i)       op_o = OP_LOAD;
        else if (inc_wr_i) op_o = OP_STEP_PAGE;
        else if (inc_rd_i) op_o = OP_STEP_FLAT;
        else               op_o = OP_HOLD;
    end

endmodule

// File: rtl/wac_step.sv
module wac_step #(
    parameter int ADDR_W = 14,
    parameter int PAGE_W = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] page_next_o,
    output logic [ADDR_W-1:0] flat_next_o
);

    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
    localparam logic [PAGE_W-1:0] ONE_P = PAGE_W'(1);

    // full-width step; the carry out of the top bit is dropped
    assign flat_next_o = addr_i + ONE_A;

    generate
        if (PAGE_W < ADDR_W) begin : g_paged
            assign page_next_o = {addr_i[ADDR_W-1:PAGE_W],
                                  addr_i[PAGE_W-1:0] + ONE_P};
        end else begin : g_single_page
            assign page_next_o = flat_next_o;
        end
    endgenerate

endmodule

// File: rtl/word_addr_ctr.sv
module word_addr_ctr
    import wac_pkg::*;
#(
    parameter int ADDR_W = WAC_ADDR_W,
    parameter int PAGE_W = WAC_PAGE_W,
    parameter int BYTE_W = WAC_BYTE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ld_hi_i,
    input  logic                       ld_lo_i,
    input  logic                       inc_wr_i,
    input  logic                       inc_rd_i,
    input  logic [BYTE_W-1:0]          addr_byte_i,
    output logic [ADDR_W-1:0]          addr_o,
    output logic [ADDR_W-PAGE_W-1:0]   row_o,
    output logic [PAGE_W-1:0]          col_o
);

    localparam int ROW_W = ADDR_W - PAGE_W;
    localparam int HI_W  = ADDR_W - BYTE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } ctr_t;

    ctr_t              ctr_d, ctr_q;
    logic [HI_W-1:0]   hi_stage;
    wac_op_e           op;
    logic [ADDR_W-1:0] page_next;
    logic [ADDR_W-1:0] flat_next;

    wac_hi_stage #(
        .HI_W   (HI_W),
        .BYTE_W (BYTE_W)
    ) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_i   (ld_hi_i),
        .byte_i (addr_byte_i),
        .hi_o   (hi_stage)
    );

    wac_op_sel u_sel (
        .ld_lo_i  (ld_lo_i),
        .inc_wr_i (inc_wr_i),
        .inc_rd_i (inc_rd_i),
        .op_o     (op)
    );

    wac_step #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_step (
        .addr_i      (ctr_q.addr),
        .page_next_o (page_next),
        .flat_next_o (flat_next)
    );

    always_comb begin
        ctr_d = ctr_q;
        unique case (op)
            OP_LOAD:      ctr_d.addr = {hi_stage, addr_byte_i};
            OP_STEP_PAGE: ctr_d.addr = page_next;
            OP_STEP_FLAT: ctr_d.addr = flat_next;
            default:      ctr_d.addr = ctr_q.addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign addr_o = ctr_q.addr;
    assign row_o  = ctr_q.addr[ADDR_W-1:PAGE_W];
    assign col_o  = ctr_q.addr[PAGE_W-1:0];

    // ROW_W is kept for readers sizing the row port
    logic [ROW_W-1:0] row_unused;
    assign row_unused = row_o;

endmodule

// File: rtl/wac_checker.sv
module wac_checker #(
    parameter int ADDR_W = 14,
    parameter int PAGE_W = 6,
    parameter int BYTE_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ld_hi_i,
    input logic                     ld_lo_i,
    input logic                     inc_wr_i,
    input logic                     inc_rd_i,
    input logic [BYTE_W-1:0]        addr_byte_i,
    input logic [ADDR_W-BYTE_W-1:0] hi_stage,
    input logic [ADDR_W-1:0]        addr_o
);

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo_i |=> addr_o == {$past(hi_stage), $past(addr_byte_i)});

    assert_stage_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_hi_i && !ld_lo_i && !inc_wr_i && !inc_rd_i) |=> $stable(addr_o));

    assert_page_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_wr_i && !ld_lo_i) |=>
            (addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W])) &&
            (addr_o[PAGE_W-1:0] == PAGE_W'($past(addr_o[PAGE_W-1:0]) + 1'b1)));

    assert_flat_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_rd_i && !inc_wr_i && !ld_lo_i) |=>
            addr_o == ADDR_W'($past(addr_o) + 1'b1));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_lo_i && !inc_wr_i && !inc_rd_i) |=> $stable(addr_o));

    assert_wr_over_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_wr_i && inc_rd_i && !ld_lo_i) |=>
            addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W]));

endmodule

bind word_addr_ctr wac_checker #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_hi_i     (ld_hi_i),
    .ld_lo_i     (ld_lo_i),
    .inc_wr_i    (inc_wr_i),
    .inc_rd_i    (inc_rd_i),
    .addr_byte_i (addr_byte_i),
    .hi_stage    (hi_stage),
    .addr_o      (addr_o)
);

// File: tb/tb_word_addr_ctr.sv
`timescale 1ns/1ps
module tb_word_addr_ctr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_hi = 1'b0, ld_lo = 1'b0, inc_wr = 1'b0, inc_rd = 1'b0;
    logic [7:0]  abyte = 8'h00;
    logic [13:0] addr_o;
    logic [7:0]  row_o;
    logic [5:0]  col_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int    m_addr = 0;
    int    m_hi = 0;
    string m_tag = "R1";

    always #4 clk = ~clk;

    word_addr_ctr dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_hi_i     (ld_hi),
        .ld_lo_i     (ld_lo),
        .inc_wr_i    (inc_wr),
        .inc_rd_i    (inc_rd),
        .addr_byte_i (abyte),
        .addr_o      (addr_o),
        .row_o       (row_o),
        .col_o       (col_o)
    );

    // behavioural reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = 0; m_hi = 0; m_tag = "R1";
        end else begin
            if (ld_lo) begin
                m_addr = m_hi * 256 + abyte;   // R3: old staged bits (R10)
                m_tag = (inc_wr || inc_rd) ? "R7" : (ld_hi ? "R10" : "R3");
            end else if (inc_wr) begin
                m_addr = (m_addr / 64) * 64 + ((m_addr % 64) + 1) % 64;
                m_tag = inc_rd ? "R8" : "R4";
            end else if (inc_rd) begin
                m_addr = (m_addr + 1) % 16384;
                m_tag = "R5";
            end else begin
                m_tag = ld_hi ? "R2" : "R6";
            end
            if (ld_hi) m_hi = abyte % 64;      // R2: bits 7:6 dropped
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (addr_o !== 14'(m_addr)) begin
                errors++;
                $display("FAIL %s addr actual %h expected %h", m_tag, addr_o, 14'(m_addr));
            end
            checks++;
            if (row_o !== 8'(m_addr / 64) || col_o !== 6'(m_addr % 64)) begin
                errors++;
                $display("FAIL R9 row/col actual %h/%h expected %h/%h",
                         row_o, col_o, 8'(m_addr / 64), 6'(m_addr % 64));
            end
        end
    end

    task automatic drive(input bit h, input bit l, input bit w, input bit r, input logic [7:0] b);
        @(negedge clk);
        ld_hi = h; ld_lo = l; inc_wr = w; inc_rd = r; abyte = b;
    endtask

    task automatic expect_addr(input logic [13:0] exp, input string tag);
        @(negedge clk);
        checks++;
        if (addr_o !== exp) begin
            errors++;
            $display("FAIL %s directed actual %h expected %h", tag, addr_o, exp);
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_addr(14'h0000, "R1");
        // R2/R3: don't-care bits set in the first byte
        drive(1, 0, 0, 0, 8'hFF);
        drive(0, 1, 0, 0, 8'hC0);
        drive(0, 0, 0, 0, 8'h00);
        expect_addr(14'h3FC0, "R3");
        // R4: write burst longer than a page
        for (int i = 0; i < 70; i++) drive(0, 0, 1, 0, 8'h00);
        drive(0, 0, 0, 0, 8'h00);
        expect_addr(14'h3FC6, "R4");
        // R5: full-array wrap on reads
        drive(1, 0, 0, 0, 8'h3F);
        drive(0, 1, 0, 0, 8'hFE);
        for (int i = 0; i < 3; i++) drive(0, 0, 0, 1, 8'h00);
        drive(0, 0, 0, 0, 8'h00);
        expect_addr(14'h0001, "R5");
        // R6: idle gap keeps the value
        for (int i = 0; i < 10; i++) drive(0, 0, 0, 0, 8'h00);
        expect_addr(14'h0001, "R6");
        // R7: load beats both increments
        drive(1, 0, 0, 0, 8'hC5);
        drive(0, 1, 1, 1, 8'h10);
        drive(0, 0, 0, 0, 8'h00);
        expect_addr(14'h0510, "R7");
        // R8: both increments, page step wins
        drive(1, 0, 0, 0, 8'h00);
        drive(0, 1, 0, 0, 8'h3F);
        drive(0, 0, 1, 1, 8'h00);
        drive(0, 0, 0, 0, 8'h00);
        expect_addr(14'h0000, "R8");
        // R10: new first byte together with second byte
        drive(1, 0, 0, 0, 8'h12);
        drive(1, 1, 0, 0, 8'h34);
        drive(0, 1, 0, 0, 8'h56);
        drive(0, 0, 0, 0, 8'h00);
        expect_addr(14'h3456, "R10");
        // pseudo-random mixed stream
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr[0] & lfsr[5], lfsr[1] & lfsr[6] & lfsr[9], lfsr[2] & lfsr[7],
                  lfsr[3] & lfsr[8], lfsr[15:8]);
        end
        drive(0, 0, 0, 0, 8'h00);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule